// File: doc/BRIEF.md
# Key-Protected Register Write Gate

This block guards one control register so that software can change it only through a fixed three-step handshake on a simple memory-mapped write bus. First a pre-write key goes to its own address, then the new value goes to the protected register's address, and last a post-write key goes to a third address. The data write lands in a shadow. The live register takes the shadow value only when the correct post-write key arrives.

A write to any of the three addresses that is not the step the handshake expects next aborts the attempt. A key address written with the wrong value also aborts it. On an abort the shadow is cleared, the sequencer goes back to idle and a one-cycle error pulse is raised. Writes to any other address do not affect the handshake. Reads of the protected address return the live value at any time and have no effect on the handshake. The key values and the three addresses are parameters, so each protected register gets its own instance with its own key pair. Typical pairs are 0xAA then 0x55 for a clock-mode register, and 0x01 then 0xF4 for a power and clock-divider register.

Top module: `keyed_reg_gate`

## Requirements
- R1: While reset (rstN low) is asserted and right after it is released, regValue is 0, seqError is 0 and the sequencer is idle.
- R2: With the defaults (PRE_ADDR 0x10, REG_ADDR 0x14, POST_ADDR 0x18, PRE_KEY 0x000000AA, POST_KEY 0x00000055, REG_W 8), the writes PRE_KEY to PRE_ADDR, then D to REG_ADDR, then POST_KEY to POST_ADDR load D[REG_W-1:0] into regValue at the clock edge that samples the post-key write.
- R3: A write to REG_ADDR never changes regValue by itself. The value is held in a shadow until the commit.
- R4: A write to PRE_ADDR whose data is not PRE_KEY raises seqError in the next cycle and leaves the sequencer idle.
- R5: A write to POST_ADDR whose data is not POST_KEY raises seqError, commits nothing and discards the shadow. A correct post key that follows it on its own is then also an error and commits nothing.
- R6: A write to any of the three addresses that is not the expected next step raises seqError and returns to idle. The expected steps are: the pre key when idle, a data write after the pre key, and the post key after the data write. A failed step is not retried as a fresh first step.
- R7: When busRe is high and busAddr equals REG_ADDR, busRdata returns regValue zero-extended, in the same cycle. For any other read busRdata is 0. Reads do not alter the sequence.
- R8: Writes to addresses other than the three are ignored. They raise no error and leave a sequence in progress intact.
- R9: seqError is high only in the cycle after an offending write. A cycle with no write, or with a valid step, is followed by seqError low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busAddr | input | ADDR_W | Bus address |
| busWdata | input | DATA_W | Bus write data |
| busWe | input | 1 | Write strobe, one write per cycle while high |
| busRe | input | 1 | Read strobe |
| busRdata | output | DATA_W | Read data, combinational |
| regValue | output | REG_W | Committed live register value |
| seqError | output | 1 | One-cycle pulse after a broken sequence |

## Verification
The hardest case to reach is a correct post key that arrives after the shadow has already been thrown away. That happens when a wrong post key, or an out-of-order write, interrupts a sequence that was one step from committing. A careless design could still commit the stale data in that case. Directed sequences build this situation on purpose, and unrelated writes and reads are spliced between steps to show that they do not break a good sequence. Random traffic then mixes these steps, biased toward the step the sequencer expects next, so that long valid chains and breaks at every stage occur many times.

// File: rtl/keyed_gate_pkg.sv
package keyed_gate_pkg;
  typedef enum logic [1:0] {
    GATE_IDLE   = 2'd0,
    GATE_ARMED  = 2'd1,
    GATE_LOADED = 2'd2
  } gateState_t;

  typedef struct packed {
    logic loadShadow;
    logic commitLive;
    logic flagError;
  } gateStrobe_t;
endpackage

// File: rtl/keyed_gate_ctrl.sv
module keyed_gate_ctrl
  import keyed_gate_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] PRE_ADDR  = 8'h10,
  parameter logic [ADDR_W-1:0] REG_ADDR  = 8'h14,
  parameter logic [ADDR_W-1:0] POST_ADDR = 8'h18,
  parameter logic [DATA_W-1:0] PRE_KEY   = 32'h0000_00AA,
  parameter logic [DATA_W-1:0] POST_KEY  = 32'h0000_0055
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              busWe,
  output gateStrobe_t       strobe
);
  gateState_t stateQ, stateD;
  logic hitPre, hitReg, hitPost, hitAny;
  logic preGood, postGood;

  assign hitPre   = busWe && (busAddr == PRE_ADDR);
  assign hitReg   = busWe && (busAddr == REG_ADDR);
  assign hitPost  = busWe && (busAddr == POST_ADDR);
  assign hitAny   = hitPre || hitReg || hitPost;
  assign preGood  = busWdata == PRE_KEY;
  assign postGood = busWdata == POST_KEY;

  always_comb begin
    stateD = stateQ;
    strobe = '0;
    if (hitAny) begin
      unique case (stateQ)
        GATE_IDLE: begin
          if (hitPre && preGood) stateD = GATE_ARMED;
          else                   strobe.flagError = 1'b1;
        end
        GATE_ARMED: begin
          if (hitReg) begin
            stateD            = GATE_LOADED;
            strobe.loadShadow = 1'b1;
          end else begin
            strobe.flagError = 1'b1;
          end
        end
        GATE_LOADED: begin
          if (hitPost && postGood) strobe.commitLive = 1'b1;
          else                     strobe.flagError  = 1'b1;
        end
        default: strobe.flagError = 1'b1;
      endcase
      if (strobe.flagError || strobe.commitLive) stateD = GATE_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= GATE_IDLE;
    else       stateQ <= stateD;
  end
endmodule

// File: rtl/keyed_gate_data.sv
module keyed_gate_data
  import keyed_gate_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int REG_W  = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h14
) (
  input  logic              clk,
  input  logic              rstN,
  input  gateStrobe_t       strobe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              busRe,
  output logic [DATA_W-1:0] busRdata,
  output logic [REG_W-1:0]  regValue,
  output logic              seqError
);
  localparam int PAD_W = DATA_W - REG_W;

  logic [REG_W-1:0]  shadowQ;
  logic [REG_W-1:0]  liveQ;
  logic              errQ;
  logic [DATA_W-1:0] liveWide;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shadowQ <= '0;
      liveQ   <= '0;
      errQ    <= 1'b0;
    end else begin
      errQ <= strobe.flagError;
      if (strobe.flagError) begin
        shadowQ <= '0;
      end else if (strobe.loadShadow) begin
        shadowQ <= busWdata[REG_W-1:0];
      end else if (strobe.commitLive) begin
        liveQ   <= shadowQ;
        shadowQ <= '0;
      end
    end
  end

  generate
    if (PAD_W > 0) begin : g_pad
      assign liveWide = {{PAD_W{1'b0}}, liveQ};
    end else begin : g_nopad
      assign liveWide = liveQ[DATA_W-1:0];
    end
  endgenerate

  assign busRdata = (busRe && (busAddr == REG_ADDR)) ? liveWide : '0;
  assign regValue = liveQ;
  assign seqError = errQ;
endmodule

// File: rtl/keyed_reg_gate.sv
module keyed_reg_gate
  import keyed_gate_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int REG_W  = 8,
  parameter logic [ADDR_W-1:0] PRE_ADDR  = 8'h10,
  parameter logic [ADDR_W-1:0] REG_ADDR  = 8'h14,
  parameter logic [ADDR_W-1:0] POST_ADDR = 8'h18,
  parameter logic [DATA_W-1:0] PRE_KEY   = 32'h0000_00AA,
  parameter logic [DATA_W-1:0] POST_KEY  = 32'h0000_0055
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              busWe,
  input  logic              busRe,
  output logic [DATA_W-1:0] busRdata,
  output logic [REG_W-1:0]  regValue,
  output logic              seqError
);
  gateStrobe_t strobe;

  keyed_gate_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .PRE_ADDR(PRE_ADDR), .REG_ADDR(REG_ADDR), .POST_ADDR(POST_ADDR),
    .PRE_KEY(PRE_KEY), .POST_KEY(POST_KEY)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWdata(busWdata),
    .busWe(busWe), .strobe(strobe)
  );

  keyed_gate_data #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_W(REG_W), .REG_ADDR(REG_ADDR)
  ) u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .busAddr(busAddr),
    .busWdata(busWdata), .busRe(busRe), .busRdata(busRdata),
    .regValue(regValue), .seqError(seqError)
  );
endmodule

// File: rtl/keyed_gate_chk.sv
module keyed_gate_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int REG_W  = 8,
  parameter logic [ADDR_W-1:0] PRE_ADDR  = 8'h10,
  parameter logic [ADDR_W-1:0] REG_ADDR  = 8'h14,
  parameter logic [ADDR_W-1:0] POST_ADDR = 8'h18,
  parameter logic [DATA_W-1:0] PRE_KEY   = 32'h0000_00AA,
  parameter logic [DATA_W-1:0] POST_KEY  = 32'h0000_0055
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] busWdata,
  input logic              busWe,
  input logic              busRe,
  input logic [DATA_W-1:0] busRdata,
  input logic [REG_W-1:0]  regValue,
  input logic              seqError
);
  logic otherAddr;
  assign otherAddr = (busAddr != PRE_ADDR) && (busAddr != REG_ADDR) && (busAddr != POST_ADDR);

  always @(posedge clk) begin
    if (rstN == 1'b0) begin
      p_reset_clear_r1: assert (regValue == '0 && seqError == 1'b0);
    end
  end

  p_commit_key_r2: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(regValue) |-> $past(busWe && busAddr == POST_ADDR && busWdata == POST_KEY));

  p_shadow_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == REG_ADDR) |=> $stable(regValue));

  p_bad_prekey_r4: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == PRE_ADDR && busWdata != PRE_KEY) |=> seqError);

  p_bad_postkey_r5: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == POST_ADDR && busWdata != POST_KEY) |=> (seqError && $stable(regValue)));

  p_read_live_r7: assert property (@(posedge clk) disable iff (!rstN)
    (busRe && busAddr == REG_ADDR) |-> (busRdata[REG_W-1:0] == regValue));

  p_read_other_r7: assert property (@(posedge clk) disable iff (!rstN)
    !(busRe && busAddr == REG_ADDR) |-> (busRdata == '0));

  p_unrelated_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && otherAddr) |=> (!seqError && $stable(regValue)));

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    !busWe |=> (!seqError && $stable(regValue)));
endmodule

bind keyed_reg_gate keyed_gate_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_W(REG_W),
  .PRE_ADDR(PRE_ADDR), .REG_ADDR(REG_ADDR), .POST_ADDR(POST_ADDR),
  .PRE_KEY(PRE_KEY), .POST_KEY(POST_KEY)
) u_chk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWdata(busWdata),
  .busWe(busWe), .busRe(busRe), .busRdata(busRdata),
  .regValue(regValue), .seqError(seqError)
);

// File: tb/keyed_reg_gate_tb.sv
module keyed_reg_gate_tb;
  localparam logic [7:0]  A_PRE  = 8'h10;
  localparam logic [7:0]  A_REG  = 8'h14;
  localparam logic [7:0]  A_POST = 8'h18;
  localparam logic [31:0] K_PRE  = 32'h0000_00AA;
  localparam logic [31:0] K_POST = 32'h0000_0055;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic        busWe = 1'b0;
  logic        busRe = 1'b0;
  logic [31:0] busRdata;
  logic [7:0]  regValue;
  logic        seqError;

  int errors = 0;
  int checks = 0;
  int expState = 0;
  logic [7:0] expShadow = '0;
  logic [7:0] expLive = '0;
  logic expErr = 1'b0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  keyed_reg_gate u_dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWdata(busWdata),
    .busWe(busWe), .busRe(busRe), .busRdata(busRdata),
    .regValue(regValue), .seqError(seqError)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic void modelWrite(input logic [7:0] a, input logic [31:0] d);
    expErr = 1'b0;
    if (a != A_PRE && a != A_REG && a != A_POST) return;
    if (expState == 0 && a == A_PRE && d == K_PRE) expState = 1;
    else if (expState == 1 && a == A_REG) begin expShadow = d[7:0]; expState = 2; end
    else if (expState == 2 && a == A_POST && d == K_POST) begin expLive = expShadow; expState = 0; end
    else begin expState = 0; expShadow = '0; expErr = 1'b1; end
  endfunction

  task automatic busWrite(input logic [7:0] a, input logic [31:0] d, input string tag);
    @(negedge clk);
    busAddr = a; busWdata = d; busWe = 1'b1; busRe = 1'b0;
    @(posedge clk);
    modelWrite(a, d);
    #1;
    chk({tag, " regValue"}, {24'h0, regValue}, {24'h0, expLive});
    chk({tag, " seqError"}, {31'h0, seqError}, {31'h0, expErr});
  endtask

  task automatic busRead(input logic [7:0] a, input string tag);
    @(negedge clk);
    busAddr = a; busWe = 1'b0; busRe = 1'b1;
    #1;
    chk({tag, " rdata"}, busRdata, (a == A_REG) ? {24'h0, expLive} : 32'h0);
    @(posedge clk);
    expErr = 1'b0;
    #1;
    chk({tag, " seqError idle"}, {31'h0, seqError}, 32'h0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'h5EED_1234));
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset regValue", {24'h0, regValue}, 32'h0);
    chk("R1 reset seqError", {31'h0, seqError}, 32'h0);
    @(negedge clk); rstN = 1'b1;
    busRead(A_REG, "R1");

    busWrite(A_PRE, K_PRE, "R2");
    busWrite(A_REG, 32'h1234_565A, "R3");
    busRead(A_REG, "R7");
    busWrite(A_POST, K_POST, "R2");
    busRead(A_REG, "R7");
    busRead(8'h40, "R7");

    busWrite(A_PRE, K_PRE, "R8");
    busWrite(8'h44, 32'hDEAD_BEEF, "R8");
    busWrite(A_REG, 32'h0000_00C3, "R8");
    busRead(A_REG, "R7");
    busWrite(8'h00, K_POST, "R8");
    busWrite(A_POST, K_POST, "R8");

    busWrite(A_PRE, 32'h0000_00AB, "R4");
    busRead(8'h00, "R9");
    busWrite(A_REG, 32'h11, "R4");

    busWrite(A_PRE, K_PRE, "R5");
    busWrite(A_REG, 32'h33, "R5");
    busWrite(A_POST, 32'h56, "R5");
    busWrite(A_POST, K_POST, "R5");
    busRead(A_REG, "R5");

    busWrite(A_REG, 32'h77, "R6");
    busWrite(A_PRE, K_PRE, "R6");
    busWrite(A_PRE, K_PRE, "R6");
    busWrite(A_PRE, K_PRE, "R6");
    busWrite(A_POST, K_POST, "R6");
    busWrite(A_PRE, K_PRE, "R6");
    busWrite(A_REG, 32'h99, "R6");
    busWrite(A_REG, 32'h98, "R6");
    busWrite(A_POST, K_POST, "R6");
    busRead(A_REG, "R9");

    for (int i = 0; i < 3000; i++) begin
      int pick = $urandom_range(0, 9);
      logic [7:0] a;
      logic [31:0] d;
      if (pick < 6) begin
        a = (expState == 0) ? A_PRE : (expState == 1) ? A_REG : A_POST;
        d = (expState == 0) ? K_PRE : (expState == 1) ? $urandom : K_POST;
        if ($urandom_range(0, 7) == 0) d = $urandom;
      end else if (pick < 8) begin
        a = (pick == 6) ? A_PRE : A_POST;
        d = ($urandom_range(0, 1) == 1) ? ((pick == 6) ? K_PRE : K_POST) : $urandom;
      end else if (pick == 8) begin
        a = 8'($urandom_range(32, 255)); d = $urandom;
      end else begin
        a = A_REG; d = $urandom;
      end
      if ($urandom_range(0, 4) == 0) busRead(($urandom_range(0, 1) == 1) ? A_REG : 8'h3C, "R7");
      else busWrite(a, d, "R2");
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule